// File: doc/BRIEF.md
# Alarm and Timer Interrupt Controller

This block watches a running real-time clock and raises a sticky alarm flag when the time matches a programmed alarm. It also runs a two-digit BCD interval timer that advances on one selectable unit strobe from the counter chain. When that timer wraps past 99, it raises a separate sticky timer flag. Each flag has its own enable, and the two enables gate the flags onto one shared active-low interrupt. Software clears a flag by writing the control byte.

The clock counters are kept outside this block. The block receives them as live BCD values and also receives one increment strobe per time unit. Bit 0 of the strobe vector is the hundredths strobe, and it also serves as the timebase tick on which clock alarms are evaluated. A byte-wide register port with a 4-bit address gives access to:

- the control byte at address 0;
- the timer at address 7;
- an eight-byte bank at addresses 8 to 15.

When alarms are switched off, the bank is plain read/write storage. When alarms are on, the bank holds the alarm settings.

Top module: `alarm_timer_irq`

## Requirements
- R1: After reset, the control byte and the timer both read 00h, both flags are 0, and `irq_no` is 1.
- R2: While control bit 2 (alarm enable) is 0:
  - addresses 8 to 15 read back exactly what was last written to them;
  - no alarm flag is set, even when their contents match the clock.
- R3: The timer advances in BCD on one strobe only. When alarms are on and the alarm kind is not "none", the strobe is the one picked by byte 8 bits [2:0]: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 days, 5 to 7 days. Otherwise the timer advances on the days strobe (`inc_i[4]`).
- R4: When the timer advances from 99, it becomes 00 and the timer flag (control bit 0) is set.
- R5: Byte 8 bits [6:4] select the alarm kind: 0 none, 1 daily, 2 weekday, 3 dated, 4 timer, 5 to 7 none. A daily alarm sets the alarm flag (control bit 1) on a tick when hundredths, seconds, minutes and hours equal bytes 9, 10, 11 and 12.
- R6: A weekday alarm requires the daily match and also requires that bit `now_wday_i` of byte 15 is set.
- R7: A dated alarm requires the daily match and also requires that date equals byte 13 and month equals byte 14.
- R8: A timer alarm sets the alarm flag when the timer advances to the value held in byte 15. Clock values are ignored for this kind.
- R9: Each flag stays set until a write to address 0 puts a 0 in its bit. Writing a 1 to a flag bit leaves the flag unchanged. If a set event and a clearing write happen in the same cycle, the set wins.
- R10: `irq_no` is 0 exactly when alarms are on and at least one of these holds:
  - the alarm flag is set and byte 8 bit 7 is 1;
  - the timer flag is set and byte 8 bit 3 is 1.
- R11: A clock match is evaluated only in a cycle with a tick (`inc_i[0]`). A match present in other cycles sets nothing.
- R12: A write to address 7 loads the timer. The load takes precedence over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 5 | Unit increment strobes: hundredths, seconds, minutes, hours, days |
| now_hund_i | input | 8 | Current hundredths, BCD |
| now_sec_i | input | 8 | Current seconds, BCD |
| now_min_i | input | 8 | Current minutes, BCD |
| now_hour_i | input | 8 | Current hours, BCD |
| now_date_i | input | 8 | Current date, BCD |
| now_month_i | input | 8 | Current month, BCD |
| now_wday_i | input | 3 | Current weekday, 0 to 6 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| timer_flag_o | output | 1 | Sticky timer-overflow flag |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The assertions assume that the timer only ever holds valid BCD digits. For this reason the stimulus loads the timer only with values between 00 and 99 whose digits are 0 to 9. The assertions also assume that a flag can only rise in a cycle in which some increment strobe was active. The bench keeps to these assumptions by changing strobes, clock values and register writes only on the falling edge. It pulses each strobe for a single cycle, and it never loads a non-BCD byte into the timer.

// File: rtl/atic_pkg.sv
package atic_pkg;

   localparam int unsigned BANK_N    = 8;
   localparam int unsigned BANK_BASE = 8;

   localparam logic [3:0] A_CTRL  = 4'd0;
   localparam logic [3:0] A_TIMER = 4'd7;

   typedef enum logic [2:0] {
      AK_NONE    = 3'd0,
      AK_DAILY   = 3'd1,
      AK_WEEKDAY = 3'd2,
      AK_DATED   = 3'd3,
      AK_TIMER   = 3'd4
   } alarm_kind_e;

   // layout of bank entry 0 (alarm setup byte)
   typedef struct packed {
      logic        alarm_ie;
      logic [2:0]  kind;
      logic        timer_ie;
      logic [2:0]  unit;
   } alarm_setup_t;

   // bank entry indices
   localparam int unsigned B_SETUP = 0;
   localparam int unsigned B_HUND  = 1;
   localparam int unsigned B_SEC   = 2;
   localparam int unsigned B_MIN   = 3;
   localparam int unsigned B_HOUR  = 4;
   localparam int unsigned B_DATE  = 5;
   localparam int unsigned B_MONTH = 6;
   localparam int unsigned B_LAST  = 7;

   function automatic alarm_kind_e kind_of(input logic [2:0] v);
      case (v)
         3'd1:    return AK_DAILY;
         3'd2:    return AK_WEEKDAY;
         3'd3:    return AK_DATED;
         3'd4:    return AK_TIMER;
         default: return AK_NONE;
      endcase
   endfunction

endpackage

// File: rtl/atic_bcd_timer.sv
module atic_bcd_timer #(
   parameter int unsigned DIGITS = 2,
   localparam int unsigned W = 4 * DIGITS
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         adv_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] nxt_o,
   output logic         wrap_o
);

   if (DIGITS < 1) begin : g_bad_digits
      $error("atic_bcd_timer: DIGITS must be at least 1");
   end

   logic [W-1:0]    cnt_q;
   logic [DIGITS:0] carry;

   assign carry[0] = adv_i;

   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      logic [3:0] cur;
      logic       at_nine;
      assign cur            = cnt_q[4*d +: 4];
      assign at_nine        = (cur == 4'd9);
      assign carry[d+1]     = carry[d] & at_nine;
      assign nxt_o[4*d +: 4] = carry[d] ? (at_nine ? 4'd0 : 4'(cur + 4'd1)) : cur;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cnt_q <= '0;
      else if (ld_i) cnt_q <= ld_val_i;
      else           cnt_q <= nxt_o;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = carry[DIGITS];

endmodule

// File: rtl/atic_regs.sv
module atic_regs
   import atic_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          we_i,
   input  logic [3:0]                    addr_i,
   input  logic [REG_W-1:0]              wdata_i,
   output logic [REG_W-1:2]              ctrl_hi_o,
   output logic [BANK_N-1:0][REG_W-1:0]  bank_o
);

   if (REG_W < 8) begin : g_bad_width
      $error("atic_regs: REG_W must be at least 8");
   end

   logic [REG_W-1:2] ctrl_hi_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ctrl_hi_q <= '0;
      else if (we_i && addr_i == A_CTRL)    ctrl_hi_q <= wdata_i[REG_W-1:2];
   end

   for (genvar i = 0; i < BANK_N; i++) begin : g_bank
      localparam logic [3:0] MY_ADDR = 4'(BANK_BASE + i);
      logic [REG_W-1:0] byte_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                        byte_q <= '0;
         else if (we_i && addr_i == MY_ADDR) byte_q <= wdata_i;
      end
      assign bank_o[i] = byte_q;
   end

   assign ctrl_hi_o = ctrl_hi_q;

endmodule

// File: rtl/atic_match.sv
module atic_match
   import atic_pkg::*;
#(
   parameter int unsigned REG_W  = 8,
   parameter int unsigned WDAY_W = 3
) (
   input  alarm_kind_e                   kind_i,
   input  logic [BANK_N-1:0][REG_W-1:0]  bank_i,
   input  logic [REG_W-1:0]              hund_i,
   input  logic [REG_W-1:0]              sec_i,
   input  logic [REG_W-1:0]              min_i,
   input  logic [REG_W-1:0]              hour_i,
   input  logic [REG_W-1:0]              date_i,
   input  logic [REG_W-1:0]              month_i,
   input  logic [WDAY_W-1:0]             wday_i,
   output logic                          hit_o
);

   if ((1 << WDAY_W) > REG_W) begin : g_bad_wday
      $error("atic_match: weekday mask does not fit one register");
   end

   logic time_eq;
   logic day_eq;
   logic wday_ok;

   assign time_eq = (hund_i == bank_i[B_HUND]) && (sec_i  == bank_i[B_SEC]) &&
                    (min_i  == bank_i[B_MIN])  && (hour_i == bank_i[B_HOUR]);
   assign day_eq  = (date_i == bank_i[B_DATE]) && (month_i == bank_i[B_MONTH]);
   assign wday_ok = bank_i[B_LAST][wday_i];

   always_comb begin
      unique case (kind_i)
         AK_DAILY:   hit_o = time_eq;
         AK_WEEKDAY: hit_o = time_eq && wday_ok;
         AK_DATED:   hit_o = time_eq && day_eq;
         default:    hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/alarm_timer_irq.sv
module alarm_timer_irq
   import atic_pkg::*;
#(
   parameter int unsigned REG_W        = 8,
   parameter int unsigned TIMER_DIGITS = 2,
   parameter int unsigned UNIT_N       = 5,
   parameter int unsigned WDAY_N       = 7,
   localparam int unsigned WDAY_W      = $clog2(WDAY_N)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [UNIT_N-1:0]  inc_i,
   input  logic [REG_W-1:0]   now_hund_i,
   input  logic [REG_W-1:0]   now_sec_i,
   input  logic [REG_W-1:0]   now_min_i,
   input  logic [REG_W-1:0]   now_hour_i,
   input  logic [REG_W-1:0]   now_date_i,
   input  logic [REG_W-1:0]   now_month_i,
   input  logic [WDAY_W-1:0]  now_wday_i,
   input  logic               reg_we_i,
   input  logic [3:0]         reg_addr_i,
   input  logic [REG_W-1:0]   reg_wdata_i,
   output logic [REG_W-1:0]   reg_rdata_o,
   output logic               alarm_flag_o,
   output logic               timer_flag_o,
   output logic               irq_no
);

   localparam int unsigned TMR_W    = 4 * TIMER_DIGITS;
   localparam int unsigned DAY_UNIT = UNIT_N - 1;

   if (TMR_W != REG_W) begin : g_bad_timer
      $error("alarm_timer_irq: timer must fill exactly one register");
   end
   if (UNIT_N < 2 || UNIT_N > 8) begin : g_bad_units
      $error("alarm_timer_irq: UNIT_N must be 2..8");
   end
   if (REG_W != $bits(alarm_setup_t)) begin : g_bad_setup
      $error("alarm_timer_irq: setup byte layout needs REG_W of 8");
   end

   logic [REG_W-1:2]             ctrl_hi;
   logic [BANK_N-1:0][REG_W-1:0] bank;
   alarm_setup_t                 setup;
   logic                         alarm_en;
   alarm_kind_e                  kind_eff;
   logic [2:0]                   unit_idx;
   logic                         timer_adv;
   logic                         timer_ld;
   logic [TMR_W-1:0]             timer_cnt;
   logic [TMR_W-1:0]             timer_nxt;
   logic                         timer_wrap;
   logic                         clk_hit;
   logic                         tick;
   logic                         ctrl_wr;
   logic                         set_alarm;
   logic                         set_timer;
   logic                         alarm_q;
   logic                         timer_q;

   atic_regs #(.REG_W(REG_W)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (reg_we_i),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .ctrl_hi_o (ctrl_hi),
      .bank_o    (bank)
   );

   assign alarm_en = ctrl_hi[2];
   assign setup    = alarm_setup_t'(bank[B_SETUP]);
   assign kind_eff = alarm_en ? kind_of(setup.kind) : AK_NONE;
   assign tick     = inc_i[0];
   assign timer_ld = reg_we_i && (reg_addr_i == A_TIMER);
   assign ctrl_wr  = reg_we_i && (reg_addr_i == A_CTRL);

   // timer unit choice: days whenever no alarm kind is active
   always_comb begin
      if (kind_eff == AK_NONE || 32'(setup.unit) > DAY_UNIT) unit_idx = 3'(DAY_UNIT);
      else                                                  unit_idx = setup.unit;
      timer_adv = 1'b0;
      for (int u = 0; u < UNIT_N; u++) begin
         if (unit_idx == 3'(u)) timer_adv = inc_i[u];
      end
   end

   atic_bcd_timer #(.DIGITS(TIMER_DIGITS)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (timer_adv),
      .ld_i     (timer_ld),
      .ld_val_i (reg_wdata_i),
      .cnt_o    (timer_cnt),
      .nxt_o    (timer_nxt),
      .wrap_o   (timer_wrap)
   );

   atic_match #(.REG_W(REG_W), .WDAY_W(WDAY_W)) u_match (
      .kind_i  (kind_eff),
      .bank_i  (bank),
      .hund_i  (now_hund_i),
      .sec_i   (now_sec_i),
      .min_i   (now_min_i),
      .hour_i  (now_hour_i),
      .date_i  (now_date_i),
      .month_i (now_month_i),
      .wday_i  (now_wday_i),
      .hit_o   (clk_hit)
   );

   assign set_alarm = (tick && clk_hit) ||
                      (kind_eff == AK_TIMER && timer_adv && !timer_ld &&
                       timer_nxt == bank[B_LAST]);
   assign set_timer = timer_wrap && !timer_ld;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         alarm_q <= 1'b0;
         timer_q <= 1'b0;
      end else begin
         if (set_alarm)    alarm_q <= 1'b1;
         else if (ctrl_wr) alarm_q <= alarm_q & reg_wdata_i[1];
         if (set_timer)    timer_q <= 1'b1;
         else if (ctrl_wr) timer_q <= timer_q & reg_wdata_i[0];
      end
   end

   always_comb begin
      if (reg_addr_i == A_CTRL)          reg_rdata_o = {ctrl_hi, alarm_q, timer_q};
      else if (reg_addr_i == A_TIMER)    reg_rdata_o = timer_cnt;
      else if (reg_addr_i[3])            reg_rdata_o = bank[reg_addr_i[2:0]];
      else                               reg_rdata_o = '0;
   end

   assign alarm_flag_o = alarm_q;
   assign timer_flag_o = timer_q;
   assign irq_no = !(alarm_en && ((alarm_q && setup.alarm_ie) || (timer_q && setup.timer_ie)));

endmodule

// File: rtl/alarm_timer_irq_chk.sv
module alarm_timer_irq_chk #(
   parameter int unsigned UNIT_N = 5,
   parameter int unsigned TMR_W  = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [UNIT_N-1:0] inc_i,
   input logic              reg_we_i,
   input logic [3:0]        reg_addr_i,
   input logic [7:0]        reg_wdata_i,
   input logic              alarm_flag_o,
   input logic              timer_flag_o,
   input logic              irq_no,
   input logic              alarm_en,
   input logic [TMR_W-1:0]  timer_cnt
);

   logic ctrl_wr;
   assign ctrl_wr = reg_we_i && (reg_addr_i == 4'd0);

   // R10: interrupt needs a pending flag
   p_irq_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_no |-> (alarm_flag_o || timer_flag_o));

   // R2: no alarm flag while alarms are off
   p_alarm_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(alarm_flag_o) |-> $past(alarm_en));

   // R11: an alarm only rises after a strobe
   p_alarm_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(alarm_flag_o) |-> $past(|inc_i));

   // R4: timer flag only rises after the timer held 99
   p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(timer_flag_o) |-> $past(timer_cnt == 8'h99));

   // R9: flags hold without a control write
   p_hold_alarm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alarm_flag_o && !ctrl_wr) |=> alarm_flag_o);
   p_hold_timer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (timer_flag_o && !ctrl_wr) |=> timer_flag_o);

   // R9: a clearing write with no strobe clears the flag
   p_clear_alarm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr && !reg_wdata_i[1] && !(|inc_i)) |=> !alarm_flag_o);

   // R3: timer stays in BCD
   p_bcd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (timer_cnt[3:0] <= 4'd9) && (timer_cnt[7:4] <= 4'd9));

endmodule

bind alarm_timer_irq alarm_timer_irq_chk #(.UNIT_N(UNIT_N), .TMR_W(TMR_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .inc_i        (inc_i),
   .reg_we_i     (reg_we_i),
   .reg_addr_i   (reg_addr_i),
   .reg_wdata_i  (reg_wdata_i),
   .alarm_flag_o (alarm_flag_o),
   .timer_flag_o (timer_flag_o),
   .irq_no       (irq_no),
   .alarm_en     (alarm_en),
   .timer_cnt    (timer_cnt)
);

// File: tb/alarm_timer_irq_tb_top.sv
`timescale 1ns/1ps
module alarm_timer_irq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] inc = '0;
   logic [7:0] hund = '0, sec = '0, mins = '0, hour = '0, date = '0, month = '0;
   logic [2:0] wday = '0;
   logic       we = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       aflag, tflag, irq_n;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   alarm_timer_irq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .inc_i(inc),
      .now_hund_i(hund), .now_sec_i(sec), .now_min_i(mins), .now_hour_i(hour),
      .now_date_i(date), .now_month_i(month), .now_wday_i(wday),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .alarm_flag_o(aflag), .timer_flag_o(tflag), .irq_no(irq_n)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      addr = a; #0.5; d = rdata;
   endtask

   task automatic pulse(input logic [4:0] m);
      @(negedge clk); inc = m;
      @(negedge clk); inc = '0;
   endtask

   task automatic set_now(input logic [7:0] h, s, mi, hr, dt, mo, input logic [2:0] wd);
      @(negedge clk);
      hund = h; sec = s; mins = mi; hour = hr; date = dt; month = mo; wday = wd;
   endtask

   task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] e);
      logic [7:0] v;
      rd(a, v);
      check(req, v, e);
   endtask

   task automatic t_reset;
      expect_reg("R1 ctrl", 4'd0, 8'h00);
      expect_reg("R1 timer", 4'd7, 8'h00);
      check("R1 irq", {7'd0, irq_n}, 8'h01);
      check("R1 flags", {6'd0, aflag, tflag}, 8'h00);
   endtask

   task automatic t_storage;
      logic [7:0] vals [8];
      vals = '{8'h11, 8'h12, 8'h34, 8'h56, 8'h07, 8'h15, 8'h06, 8'hFF};
      wr(4'd0, 8'h00);
      for (int i = 0; i < 8; i++) wr(4'(8 + i), vals[i]);
      for (int i = 0; i < 8; i++) expect_reg("R2 storage readback", 4'(8 + i), vals[i]);
      set_now(8'h12, 8'h34, 8'h56, 8'h07, 8'h15, 8'h06, 3'd3);
      pulse(5'b00001);
      expect_reg("R2 no alarm while off", 4'd0, 8'h00);
      pulse(5'b00010);
      expect_reg("R3 unit ignored while off", 4'd7, 8'h00);
      pulse(5'b10000);
      expect_reg("R3 days when off", 4'd7, 8'h01);
      set_now(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 3'd0);
   endtask

   task automatic t_load_count;
      wr(4'd0, 8'h04);
      wr(4'd8, 8'h11);
      wr(4'd7, 8'h38);
      expect_reg("R12 load", 4'd7, 8'h38);
      pulse(5'b00010);
      expect_reg("R3 seconds advance", 4'd7, 8'h39);
      pulse(5'b00010);
      expect_reg("R3 BCD carry", 4'd7, 8'h40);
      pulse(5'b10000);
      expect_reg("R3 other unit ignored", 4'd7, 8'h40);
      wr(4'd8, 8'h15);
      pulse(5'b10000);
      expect_reg("R3 unit 5 is days", 4'd7, 8'h41);
   endtask

   task automatic t_overflow;
      wr(4'd8, 8'h11);
      wr(4'd7, 8'h99);
      pulse(5'b00010);
      expect_reg("R4 wrap to 00", 4'd7, 8'h00);
      expect_reg("R4 timer flag", 4'd0, 8'h05);
      check("R10 gated timer irq", {7'd0, irq_n}, 8'h01);
      wr(4'd8, 8'h19);
      check("R10 timer irq", {7'd0, irq_n}, 8'h00);
      wr(4'd0, 8'h05);
      expect_reg("R9 write 1 keeps", 4'd0, 8'h05);
      pulse(5'b00100);
      expect_reg("R9 sticky", 4'd0, 8'h05);
      wr(4'd0, 8'h04);
      expect_reg("R9 cleared", 4'd0, 8'h04);
      check("R10 irq released", {7'd0, irq_n}, 8'h01);
   endtask

   task automatic t_daily;
      wr(4'd8, 8'h90);
      set_now(8'h12, 8'h34, 8'h56, 8'h07, 8'h01, 8'h01, 3'd0);
      pulse(5'b00010);
      check("R11 no tick no alarm", {7'd0, aflag}, 8'h00);
      pulse(5'b00001);
      check("R5 daily hit", {7'd0, aflag}, 8'h01);
      check("R10 alarm irq", {7'd0, irq_n}, 8'h00);
      wr(4'd0, 8'h04);
      set_now(8'h12, 8'h34, 8'h56, 8'h08, 8'h01, 8'h01, 3'd0);
      pulse(5'b00001);
      check("R5 hour mismatch", {7'd0, aflag}, 8'h00);
   endtask

   task automatic t_weekday;
      wr(4'd8, 8'hA0);
      wr(4'd15, 8'h08);
      set_now(8'h12, 8'h34, 8'h56, 8'h07, 8'h01, 8'h01, 3'd3);
      pulse(5'b00001);
      check("R6 weekday hit", {7'd0, aflag}, 8'h01);
      wr(4'd0, 8'h04);
      set_now(8'h12, 8'h34, 8'h56, 8'h07, 8'h01, 8'h01, 3'd2);
      pulse(5'b00001);
      check("R6 weekday masked", {7'd0, aflag}, 8'h00);
   endtask

   task automatic t_dated;
      wr(4'd8, 8'hB0);
      set_now(8'h12, 8'h34, 8'h56, 8'h07, 8'h15, 8'h06, 3'd2);
      pulse(5'b00001);
      check("R7 dated hit", {7'd0, aflag}, 8'h01);
      wr(4'd0, 8'h04);
      set_now(8'h12, 8'h34, 8'h56, 8'h07, 8'h15, 8'h07, 3'd2);
      pulse(5'b00001);
      check("R7 month mismatch", {7'd0, aflag}, 8'h00);
   endtask

   task automatic t_timer_alarm;
      wr(4'd8, 8'hC0);
      wr(4'd15, 8'h05);
      wr(4'd7, 8'h03);
      set_now(8'h12, 8'h34, 8'h56, 8'h07, 8'h15, 8'h06, 3'd3);
      pulse(5'b00001);
      expect_reg("R8 timer step", 4'd7, 8'h04);
      check("R8 no early alarm", {7'd0, aflag}, 8'h00);
      pulse(5'b00001);
      check("R8 timer alarm", {7'd0, aflag}, 8'h01);
      check("R10 timer-kind irq", {7'd0, irq_n}, 8'h00);
      wr(4'd0, 8'h04);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_storage();
      t_load_count();
      t_overflow();
      t_daily();
      t_weekday();
      t_dated();
      t_timer_alarm();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule